// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks the page frame to give up when a page fault needs room. It tracks N resident frames on a circle, in the order they were filled. For each frame it holds a referenced flag and a modified flag. The address translator sets these flags with per-frame pulses, one for a reference and one for a write.

When a frame is needed, the fault handler raises a one-cycle eviction request. A hand pointer then walks the circle one frame per clock. A frame whose referenced flag is set is spared: its flag is cleared and the hand moves on. The first frame found with a clear referenced flag becomes the victim. The block reports that frame's index, plus a flag telling the handler whether the frame is dirty and must be written back before reuse. The victim slot is then treated as holding a freshly installed page: its referenced flag is set, its modified flag is cleared, and the hand parks on the next frame.

Top module: `clock_victim_sel`

## Requirements
- R1: After synchronous reset, the hand points at frame 0, every referenced and modified flag is clear, and `victim_valid` is low.
- R2: An `evict_req` pulse taken while the block is idle starts a search at the next clock edge. The search begins at the current hand position and examines one frame per clock.
- R3: When the search meets a frame whose referenced flag is 1, it clears that flag and advances the hand without choosing the frame.
- R4: The first examined frame whose referenced flag is 0 is chosen. `victim_valid` is high for exactly one cycle, with `victim_idx` equal to that frame's number (binary, 0 to N-1). The number of cycles from the accepting edge to `victim_valid` equals the number of frames examined.
- R5: `victim_wb` is 1 when the chosen frame's modified flag was 1, and 0 when the frame is clean.
- R6: After a victim is reported, its referenced flag is 1, its modified flag is 0, and the hand points at the frame after it.
- R7: If every referenced flag is set when the search starts, the search clears all of them and then chooses the frame it started from, N+1 cycles after the accepting edge.
- R8: Bit i of `ref_pulse` (or `mod_pulse`) sets frame i's referenced (or modified) flag at the next edge, at any time. A set wins over a clear aimed at the same flag in the same cycle. A reference to a frame the running search has not yet reached makes the search skip that frame.
- R9: `evict_req` is ignored while a search is running. It starts no second search.
- R10: The hand wraps from frame N-1 to frame 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | N_FRAMES | Per-frame reference pulse, sets the referenced flag |
| mod_pulse | input | N_FRAMES | Per-frame write pulse, sets the modified flag |
| evict_req | input | 1 | One-cycle request for a victim frame |
| victim_valid | output | 1 | One-cycle strobe marking a chosen victim |
| victim_idx | output | $clog2(N_FRAMES) | Number of the chosen frame |
| victim_wb | output | 1 | Chosen frame is dirty and needs write-back |

## Verification
The embedded assertions check the following on every cycle:
- a referenced frame passed by the hand loses its flag unless a reference pulse arrives in the same cycle;
- the installed victim ends up referenced and clean;
- the hand advances by one, with wrap, on each examined frame;
- the victim strobe lasts one cycle;
- no search runs longer than N+1 cycles.

Some behaviour only the directed scenarios can show. These are which frame is chosen for a given flag history, the exact latency, the write-back flag against earlier writes, and a reference arriving mid-search that diverts the choice. They also cover an eviction request during a search being dropped.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;

    typedef enum logic {
        SEL_IDLE = 1'b0,
        SEL_SCAN = 1'b1
    } sel_state_e;

    typedef struct packed {
        logic spare;
        logic take;
    } probe_t;

    function automatic int unsigned ring_next(input int unsigned pos, input int unsigned ring_len);
        return (pos + 1 >= ring_len) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/frame_flags.sv
module frame_flags #(
    parameter int N_FRAMES = 8,
    localparam int IW = $clog2(N_FRAMES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_FRAMES-1:0] ref_pulse,
    input  logic [N_FRAMES-1:0] mod_pulse,
    input  logic                clr_en,
    input  logic                inst_en,
    input  logic [IW-1:0]       sel_idx,
    output logic [N_FRAMES-1:0] r_flags,
    output logic [N_FRAMES-1:0] m_flags
);

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
        logic hit;
        assign hit = (sel_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_flags[g] <= 1'b0;
            end else if (ref_pulse[g] || (inst_en && hit)) begin
                r_flags[g] <= 1'b1;
            end else if (clr_en && hit) begin
                r_flags[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                m_flags[g] <= 1'b0;
            end else if (mod_pulse[g]) begin
                m_flags[g] <= 1'b1;
            end else if (inst_en && hit) begin
                m_flags[g] <= 1'b0;
            end
        end
    end

    // R3
    spared_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !ref_pulse[sel_idx]) |=> !r_flags[$past(sel_idx)]);

    // R6
    install_ref_chk: assert property (@(posedge clk) disable iff (rst)
        inst_en |=> r_flags[$past(sel_idx)]);

    // R6
    install_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (inst_en && !mod_pulse[sel_idx]) |=> !m_flags[$past(sel_idx)]);

endmodule

// File: rtl/hand_ctrl.sv
module hand_ctrl
    import clock_sel_pkg::*;
#(
    parameter int N_FRAMES = 8,
    localparam int IW = $clog2(N_FRAMES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evict_req,
    input  logic [N_FRAMES-1:0] r_flags,
    input  logic [N_FRAMES-1:0] m_flags,
    output logic [IW-1:0]       hand,
    output logic                clr_en,
    output logic                inst_en,
    output logic                victim_valid,
    output logic [IW-1:0]       victim_idx,
    output logic                victim_wb
);

    sel_state_e state;
    probe_t     probe;
    logic [IW-1:0] hand_nx;

    always_comb begin
        probe.spare = (state == SEL_SCAN) && r_flags[hand];
        probe.take  = (state == SEL_SCAN) && !r_flags[hand];
        clr_en      = probe.spare;
        inst_en     = probe.take;
        hand_nx     = IW'(ring_next(int'(hand), N_FRAMES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SEL_IDLE;
            hand         <= '0;
            victim_valid <= 1'b0;
            victim_idx   <= '0;
            victim_wb    <= 1'b0;
        end else begin
            victim_valid <= 1'b0;
            case (state)
                SEL_IDLE: if (evict_req) state <= SEL_SCAN;
                SEL_SCAN: begin
                    hand <= hand_nx;
                    if (probe.take) begin
                        victim_valid <= 1'b1;
                        victim_idx   <= hand;
                        victim_wb    <= m_flags[hand];
                        state        <= SEL_IDLE;
                    end
                end
                default: state <= SEL_IDLE;
            endcase
        end
    end

    // Search length watch: counts examined frames of the current search.
    logic [IW+1:0] scan_len;
    always_ff @(posedge clk) begin
        if (rst || state == SEL_IDLE) scan_len <= '0;
        else                          scan_len <= scan_len + 1'b1;
    end

    // R7
    scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEL_SCAN) |-> (int'(scan_len) < N_FRAMES + 1));

    // R4
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        victim_valid |=> !victim_valid);

    // R10
    hand_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEL_SCAN) |=>
            (hand == ((int'($past(hand)) == N_FRAMES - 1) ? '0 : $past(hand) + 1'b1)));

    // R6
    park_after_chk: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> (hand == ((int'(victim_idx) == N_FRAMES - 1) ? '0 : victim_idx + 1'b1)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEL_IDLE) |=> $stable(hand));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int N_FRAMES = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_FRAMES-1:0]          ref_pulse,
    input  logic [N_FRAMES-1:0]          mod_pulse,
    input  logic                         evict_req,
    output logic                         victim_valid,
    output logic [$clog2(N_FRAMES)-1:0]  victim_idx,
    output logic                         victim_wb
);

    localparam int IW = $clog2(N_FRAMES);

    logic [N_FRAMES-1:0] r_flags;
    logic [N_FRAMES-1:0] m_flags;
    logic [IW-1:0]       hand;
    logic                clr_en;
    logic                inst_en;

    hand_ctrl #(.N_FRAMES(N_FRAMES)) u_hand (
        .clk          (clk),
        .rst          (rst),
        .evict_req    (evict_req),
        .r_flags      (r_flags),
        .m_flags      (m_flags),
        .hand         (hand),
        .clr_en       (clr_en),
        .inst_en      (inst_en),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .victim_wb    (victim_wb)
    );

    frame_flags #(.N_FRAMES(N_FRAMES)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .mod_pulse (mod_pulse),
        .clr_en    (clr_en),
        .inst_en   (inst_en),
        .sel_idx   (hand),
        .r_flags   (r_flags),
        .m_flags   (m_flags)
    );

endmodule

// File: tb/test_clock_victim_sel.sv
`timescale 1ns/1ps
module test_clock_victim_sel;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] ref_pulse = '0;
    logic [N-1:0] mod_pulse = '0;
    logic         evict_req = 1'b0;
    logic         victim_valid;
    logic [2:0]   victim_idx;
    logic         victim_wb;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    clock_victim_sel #(.N_FRAMES(N)) i_clock_victim_sel (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .mod_pulse(mod_pulse),
        .evict_req(evict_req), .victim_valid(victim_valid),
        .victim_idx(victim_idx), .victim_wb(victim_wb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Waits for the strobe; lat counts clock edges after the accepting edge.
    task automatic wait_victim(input int start_lat, output int lat);
        lat = start_lat;
        while (!victim_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic pulse_ref(input logic [N-1:0] v);
        ref_pulse = v;
        @(negedge clk);
        ref_pulse = '0;
    endtask

    task automatic pulse_mod(input logic [N-1:0] v);
        mod_pulse = v;
        @(negedge clk);
        mod_pulse = '0;
    endtask

    task automatic evict_expect(input int exp_idx, input int exp_wb, input int exp_lat, input string req);
        int lat;
        evict_req = 1'b1;
        @(negedge clk);
        evict_req = 1'b0;
        wait_victim(0, lat);
        check(victim_valid === 1'b1, {req, " strobe"}, int'(victim_valid), 1);
        check(int'(victim_idx) == exp_idx, {req, " idx"}, int'(victim_idx), exp_idx);
        check(int'(victim_wb) == exp_wb, {req, " wb"}, int'(victim_wb), exp_wb);
        check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        @(negedge clk);
        check(victim_valid === 1'b0, "R4 one-cycle strobe", int'(victim_valid), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(victim_valid === 1'b0, "R1 reset strobe", int'(victim_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(victim_valid === 1'b0, "R1 idle strobe", int'(victim_valid), 0);
        evict_expect(0, 0, 1, "R1 R2 first victim at frame 0");
    endtask

    task automatic t_dirty;
        pulse_mod(8'b0000_0100);
        evict_expect(1, 0, 1, "R6 hand parks after victim");
        evict_expect(2, 1, 1, "R5 dirty victim");
    endtask

    task automatic t_second_chance;
        pulse_ref(8'b0001_1000);
        evict_expect(5, 0, 3, "R3 skip referenced");
        evict_expect(6, 0, 1, "R4 clean pick");
        evict_expect(7, 0, 1, "R10 before wrap");
        evict_expect(3, 0, 4, "R10 R3 wrap and skip installed");
        evict_expect(4, 0, 1, "R3 flag cleared by earlier pass");
        evict_expect(0, 0, 4, "R3 spared run");
        evict_expect(1, 0, 1, "R6 installed then cleared");
        evict_expect(2, 0, 1, "R6 modified flag cleared on install");
    endtask

    task automatic t_all_set;
        pulse_ref('1);
        evict_expect(3, 0, N + 1, "R7 full lap");
    endtask

    task automatic t_midsearch;
        int lat;
        pulse_ref(8'b1111_0000);
        evict_req = 1'b1;
        @(negedge clk);
        evict_req = 1'b0;
        @(negedge clk);
        // R8 reference frame 0 ahead of the hand; R9 second request while busy
        ref_pulse = 8'b0000_0001;
        evict_req = 1'b1;
        @(negedge clk);
        ref_pulse = '0;
        evict_req = 1'b0;
        wait_victim(2, lat);
        check(int'(victim_idx) == 1, "R8 late reference honoured idx", int'(victim_idx), 1);
        check(lat == 6, "R8 late reference latency", lat, 6);
        check(int'(victim_wb) == 0, "R8 wb", int'(victim_wb), 0);
        begin
            int extra = 0;
            for (int k = 0; k < 2 * N; k++) begin
                @(negedge clk);
                if (victim_valid) extra++;
            end
            check(extra == 0, "R9 busy request ignored", extra, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_dirty;
        t_second_chance;
        t_all_set;
        t_midsearch;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule